// File: doc/BRIEF.md
# Two-Source Vectored Interrupt Controller

This block sits next to a small 4-bit processor core and decides when the core is diverted to an interrupt routine. It has two sources. The first is an asynchronous input pin whose active edge is chosen by software. The second is a one-cycle underflow pulse from a timer. Each source owns a sticky request flag and an enable bit. A single global enable gates both sources. When a request is pending, its source is enabled and the global enable is set, the controller issues a vector address at an instruction boundary. With that vector it gives a one-cycle strobe, so that the core can put its data pointer, carry and skip state into a one-level save register.

The core tells the controller when each machine cycle ends and when each instruction ends. It also passes on the decoded enable, disable, return and skip-test commands of the instruction that is finishing. A request flag can also be polled with the interrupt kept off. A skip test on a source whose enable bit is clear returns that flag and consumes it. A four-bit control register holds the two enable bits and the edge select.

Top module: `irqv_ctrl`

## Requirements
- R1: A vector is issued only when a source's request flag, that source's enable bit and the global enable are all 1. A pending flag whose enable bit is 0 never causes a vector.
- R2: A request flag is set by its trigger whether or not the source is enabled. It stays set until its interrupt is taken or a valid skip test reads it. If a trigger and a clear arrive in the same cycle, the flag stays set.
- R3: Taking an interrupt clears the global enable and clears only the flag of the serviced source. `vec_req` and `save_stb` are high together for exactly one cycle.
- R4: With both sources live, the external source wins and `vec_addr` is 0x080. The timer source gives 0x082.
- R5: An enable command (`cmd_ei` with `instr_end`) sets `gie` only at the end of the next instruction. So enable followed by return gives `gie`=1 after the return. A return command pulses `restore_stb` for one cycle, and `gie` rises only at an instruction end.
- R6: The interrupt condition is registered on a machine-cycle tick. The vector is issued at the next tick that also ends an instruction. With one-cycle instructions, `vec_req` rises two instructions after `gie` rises. Ticks without `instr_end` delay the vector.
- R7: The pin passes through two synchronizing flops before edge detection. Control bit 2 selects the edge: 1 is falling, 0 is rising. Each selected edge sets the flag once, and the opposite edge or a steady level sets nothing.
- R8: Control bit 0 enables the external source and bit 1 enables the timer source. The register resets to 0000. A skip test (`skip_ext`/`skip_tmr` with `instr_end`) is valid only when the source's enable bit is 0. In that case `skip_hit` returns the flag in the next cycle and the flag is cleared. Otherwise `skip_hit` is 0 and the flag is unchanged.
- R9: A disable command clears `gie` and any pending enable at the end of its instruction.
- R10: After reset, `gie`, `vec_req`, `save_stb`, `restore_stb` and `skip_hit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| tmr_uflow | input | 1 | One-cycle timer underflow pulse |
| mc_tick | input | 1 | End of a machine cycle |
| instr_end | input | 1 | End of an instruction (with mc_tick) |
| cmd_ei | input | 1 | Finishing instruction is enable-interrupts |
| cmd_di | input | 1 | Finishing instruction is disable-interrupts |
| cmd_rti | input | 1 | Finishing instruction is return-from-interrupt |
| skip_ext | input | 1 | Skip test of the external flag |
| skip_tmr | input | 1 | Skip test of the timer flag |
| ctrl_we | input | 1 | Control register write |
| ctrl_wdata | input | 4 | bit0 ext enable, bit1 timer enable, bit2 falling edge, bit3 spare |
| gie | output | 1 | Global interrupt enable |
| vec_req | output | 1 | One-cycle vector request |
| vec_addr | output | 11 | Vector address |
| save_stb | output | 1 | Save core state into the interrupt save register |
| restore_stb | output | 1 | Restore core state on return |
| skip_hit | output | 1 | Result of the last valid skip test |

## Verification
The vector path is tried with a lone timer request, a lone external request, both requests together, and an enabled flag whose source enable is clear. These four cases separate the priority order, the clearing of the serviced flag only, and the three-way enable condition. Instruction streams made of one-cycle instructions and streams with ticks lacking an instruction end show where the vector lands, and whether enable takes effect one instruction late. Random interleavings of underflow pulses and skip tests, checked against a model of a sticky flag, show whether the flag keeps its value and whether a trigger in the same cycle as a clear is lost. Pin toggles with each edge selection show whether the wrong edge or a held level sets the flag.

// File: rtl/irqv_pkg.sv
// Package: shared constants and control register layout for the
// two-source vectored interrupt controller.
package irqv_pkg;
    localparam int CTRL_W  = 4;
    localparam int NSRC    = 2;
    localparam int SRC_EXT = 0;   // higher priority
    localparam int SRC_TMR = 1;

    // Control register; field order matches bit positions 3..0.
    typedef struct packed {
        logic spare;
        logic fall_sel;
        logic en_tmr;
        logic en_ext;
    } ctrl_t;
endpackage

// File: rtl/irqv_edge_sync.sv
// Synchronizes an asynchronous pin through STAGES flops and emits a
// one-cycle pulse on the selected edge. Assumes STAGES >= 2 and that
// the pin stays stable for at least one cycle between edges.
module irqv_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic edge_pulse
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              rise, fall;

    // Shift the pin through the synchronizer and keep the last value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            prev_q <= sync_q[STAGES-1];
        end
    end

    // Decode both edges and pick the one selected by software.
    always_comb begin
        rise       = sync_q[STAGES-1] & ~prev_q;
        fall       = ~sync_q[STAGES-1] & prev_q;
        edge_pulse = fall_sel ? fall : rise;
    end
endmodule

// File: rtl/irqv_req_flag.sv
// Sticky request flag. A set in the same cycle as a clear wins, so
// no trigger is ever lost.
module irqv_req_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Hold the request until it is consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= set | (flag & ~clr);
    end
endmodule

// File: rtl/irqv_arbiter.sv
// Global enable, delayed enable, priority selection, vector issue
// and skip-test evaluation. Assumes commands are qualified by
// instr_end and that instr_end only arrives together with mc_tick.
module irqv_arbiter
    import irqv_pkg::*;
#(
    parameter int              ADDR_W  = 11,
    parameter logic [ADDR_W-1:0] VEC_EXT = 11'h080,
    parameter logic [ADDR_W-1:0] VEC_TMR = 11'h082
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_tick,
    input  logic              instr_end,
    input  logic              cmd_ei,
    input  logic              cmd_di,
    input  logic              cmd_rti,
    input  logic [NSRC-1:0]   skip_req,
    input  logic [NSRC-1:0]   src_en,
    input  logic [NSRC-1:0]   src_flag,
    output logic [NSRC-1:0]   flag_clr,
    output logic              gie,
    output logic              vec_req,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              save_stb,
    output logic              restore_stb,
    output logic              skip_hit
);
    logic [NSRC-1:0] live, win, skip_ok;
    logic            cond, armed_q, fire, ei_pend_q, hit_d;

    // Combine flags, enables and priority into the take decision.
    always_comb begin
        live     = src_flag & src_en;
        cond     = gie & (|live);
        fire     = mc_tick & instr_end & armed_q & cond;
        win      = '0;
        win[SRC_EXT] = live[SRC_EXT];
        win[SRC_TMR] = live[SRC_TMR] & ~live[SRC_EXT];
        skip_ok  = {NSRC{instr_end}} & skip_req & ~src_en;
        hit_d    = |(skip_ok & src_flag);
        flag_clr = (fire ? win : '0) | skip_ok;
    end

    // Global enable with one-instruction delay on enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie       <= 1'b0;
            ei_pend_q <= 1'b0;
        end else begin
            if (instr_end) begin
                if (cmd_di) begin
                    gie       <= 1'b0;
                    ei_pend_q <= 1'b0;
                end else begin
                    if (ei_pend_q) gie <= 1'b1;
                    ei_pend_q <= cmd_ei;
                end
            end
            if (fire) gie <= 1'b0;
        end
    end

    // Register the condition at each machine-cycle tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed_q <= 1'b0;
        else if (mc_tick) armed_q <= cond & ~fire;
    end

    // Issue the vector, the save and restore strobes, and the skip result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_req     <= 1'b0;
            save_stb    <= 1'b0;
            restore_stb <= 1'b0;
            skip_hit    <= 1'b0;
            vec_addr    <= '0;
        end else begin
            vec_req     <= fire;
            save_stb    <= fire;
            restore_stb <= instr_end & cmd_rti;
            skip_hit    <= hit_d;
            if (fire) vec_addr <= win[SRC_EXT] ? VEC_EXT : VEC_TMR;
        end
    end
endmodule

// File: rtl/irqv_ctrl.sv
// Top of the two-source vectored interrupt controller: control
// register, pin edge detector, one sticky flag per source and the
// arbiter. The timer counter and the core datapath live elsewhere.
module irqv_ctrl
    import irqv_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PAGE_W      = 7,
    parameter int VEC_PAGE    = 1,
    parameter int EXT_OFS     = 0,
    parameter int TMR_OFS     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_pin,
    input  logic              tmr_uflow,
    input  logic              mc_tick,
    input  logic              instr_end,
    input  logic              cmd_ei,
    input  logic              cmd_di,
    input  logic              cmd_rti,
    input  logic              skip_ext,
    input  logic              skip_tmr,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic              gie,
    output logic              vec_req,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              save_stb,
    output logic              restore_stb,
    output logic              skip_hit
);
    localparam logic [ADDR_W-1:0] PAGE_BASE = ADDR_W'(VEC_PAGE) << PAGE_W;
    localparam logic [ADDR_W-1:0] VEC_EXT   = PAGE_BASE | ADDR_W'(EXT_OFS);
    localparam logic [ADDR_W-1:0] VEC_TMR   = PAGE_BASE | ADDR_W'(TMR_OFS);

    ctrl_t           ctrl_q;
    logic            ext_edge;
    logic [NSRC-1:0] trig, flags, clrs, ens, skips;

    // Software-written control register.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= ctrl_t'(ctrl_wdata);
    end

    // Gather per-source vectors.
    always_comb begin
        trig[SRC_EXT]  = ext_edge;
        trig[SRC_TMR]  = tmr_uflow;
        ens[SRC_EXT]   = ctrl_q.en_ext;
        ens[SRC_TMR]   = ctrl_q.en_tmr;
        skips[SRC_EXT] = skip_ext;
        skips[SRC_TMR] = skip_tmr;
    end

    irqv_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin(ext_pin),
        .fall_sel(ctrl_q.fall_sel), .edge_pulse(ext_edge)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_flag
        irqv_req_flag u_flag (
            .clk(clk), .rst_n(rst_n), .set(trig[i]),
            .clr(clrs[i]), .flag(flags[i])
        );
    end

    irqv_arbiter #(.ADDR_W(ADDR_W), .VEC_EXT(VEC_EXT), .VEC_TMR(VEC_TMR)) u_arb (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .instr_end(instr_end),
        .cmd_ei(cmd_ei), .cmd_di(cmd_di), .cmd_rti(cmd_rti),
        .skip_req(skips), .src_en(ens), .src_flag(flags), .flag_clr(clrs),
        .gie(gie), .vec_req(vec_req), .vec_addr(vec_addr),
        .save_stb(save_stb), .restore_stb(restore_stb), .skip_hit(skip_hit)
    );
endmodule

// File: rtl/irqv_ctrl_chk.sv
// Checker for irqv_ctrl: temporal properties on the top-level ports.
module irqv_ctrl_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_end,
    input logic              cmd_rti,
    input logic              skip_ext,
    input logic              skip_tmr,
    input logic              gie,
    input logic              vec_req,
    input logic [ADDR_W-1:0] vec_addr,
    input logic              save_stb,
    input logic              restore_stb,
    input logic              skip_hit
);
    assert_take_needs_gie_R1: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |-> $past(gie));
    assert_take_clears_gie_R3: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |-> !gie);
    assert_vec_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |=> !vec_req);
    assert_save_with_vec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        save_stb |-> vec_req);
    assert_vec_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |-> (vec_addr == 11'h080 || vec_addr == 11'h082));
    assert_gie_at_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gie) |-> $past(instr_end));
    assert_restore_from_rti_R5: assert property (@(posedge clk) disable iff (!rst_n)
        restore_stb |-> $past(cmd_rti && instr_end));
    assert_skip_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        skip_hit |-> $past((skip_ext || skip_tmr) && instr_end));
endmodule

bind irqv_ctrl irqv_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .instr_end(instr_end), .cmd_rti(cmd_rti),
    .skip_ext(skip_ext), .skip_tmr(skip_tmr), .gie(gie), .vec_req(vec_req),
    .vec_addr(vec_addr), .save_stb(save_stb), .restore_stb(restore_stb),
    .skip_hit(skip_hit)
);

// File: tb/tb_irqv_ctrl.sv
module tb_irqv_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_pin = 0, tmr_uflow = 0, mc_tick = 0, instr_end = 0;
    logic cmd_ei = 0, cmd_di = 0, cmd_rti = 0, skip_ext = 0, skip_tmr = 0;
    logic ctrl_we = 0;
    logic [3:0] ctrl_wdata = '0;
    logic gie, vec_req, save_stb, restore_stb, skip_hit;
    logic [10:0] vec_addr;
    int checks = 0, failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irqv_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tmr_uflow(tmr_uflow),
        .mc_tick(mc_tick), .instr_end(instr_end), .cmd_ei(cmd_ei),
        .cmd_di(cmd_di), .cmd_rti(cmd_rti), .skip_ext(skip_ext),
        .skip_tmr(skip_tmr), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .gie(gie), .vec_req(vec_req), .vec_addr(vec_addr),
        .save_stb(save_stb), .restore_stb(restore_stb), .skip_hit(skip_hit)
    );

    function automatic logic [10:0] exp_vec(input logic ext_live, input logic tmr_live);
        return ext_live ? 11'h080 : (tmr_live ? 11'h082 : 11'h000);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock with a machine-cycle tick; inputs then return to idle.
    task automatic cyc(input logic iend);
        mc_tick = 1'b1;
        instr_end = iend;
        @(posedge clk);
        #2;
        mc_tick = 0; instr_end = 0; cmd_ei = 0; cmd_di = 0; cmd_rti = 0;
        skip_ext = 0; skip_tmr = 0; tmr_uflow = 0; ctrl_we = 0;
    endtask

    task automatic wr_ctrl(input logic [3:0] v);
        ctrl_we = 1'b1;
        ctrl_wdata = v;
        cyc(1'b1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1);
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        if (!done) $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic model;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;

        // R10: reset state
        chk("R10 gie", gie, 0);
        chk("R10 vec_req", vec_req, 0);
        chk("R10 strobes", {save_stb, restore_stb, skip_hit}, 0);

        // R8: enables reset to 0 so a timer skip test is valid
        tmr_uflow = 1; cyc(1'b0);
        skip_tmr = 1; cyc(1'b1);
        chk("R8 skip after reset", skip_hit, 1);
        skip_tmr = 1; cyc(1'b1);
        chk("R8 skip consumes flag", skip_hit, 0);

        // R7: rising edge selected (bit2=0)
        ext_pin = 1; idle(4);
        skip_ext = 1; cyc(1'b1);
        chk("R7 rising sets flag", skip_hit, 1);
        idle(3);
        skip_ext = 1; cyc(1'b1);
        chk("R7 held level no re-set", skip_hit, 0);
        ext_pin = 0; idle(4);
        skip_ext = 1; cyc(1'b1);
        chk("R7 falling ignored when rising selected", skip_hit, 0);
        // R7: falling edge selected (bit2=1)
        wr_ctrl(4'b0100);
        ext_pin = 1; idle(4);
        skip_ext = 1; cyc(1'b1);
        chk("R7 rising ignored when falling selected", skip_hit, 0);
        ext_pin = 0; idle(4);
        skip_ext = 1; cyc(1'b1);
        chk("R7 falling sets flag", skip_hit, 1);

        // R1/R2: pending flag with its enable clear never vectors
        wr_ctrl(4'b0000);
        tmr_uflow = 1; cyc(1'b1);
        cmd_ei = 1; cyc(1'b1);
        idle(5);
        chk("R1 gie set", gie, 1);
        chk("R1 no vector when source disabled", vec_req, 0);
        // R9: disable
        cmd_di = 1; cyc(1'b1);
        chk("R9 di clears gie", gie, 0);
        skip_tmr = 1; cyc(1'b1);
        chk("R2 flag kept while disabled", skip_hit, 1);

        // R8: skip invalid when enabled, flag untouched
        wr_ctrl(4'b0010);
        tmr_uflow = 1; cyc(1'b1);
        skip_tmr = 1; cyc(1'b1);
        chk("R8 skip invalid when enabled", skip_hit, 0);
        wr_ctrl(4'b0000);
        skip_tmr = 1; cyc(1'b1);
        chk("R8 flag unchanged by invalid skip", skip_hit, 1);

        // R5/R6/R3/R4: timer vector, one-cycle instructions
        wr_ctrl(4'b0010);
        tmr_uflow = 1; cyc(1'b1);
        cmd_ei = 1; cyc(1'b1);
        chk("R5 ei not immediate", gie, 0);
        cyc(1'b1);
        chk("R5 ei after next instruction", gie, 1);
        chk("R6 no vector yet", vec_req, 0);
        cyc(1'b1);
        chk("R6 condition registering", vec_req, 0);
        cyc(1'b1);
        chk("R6 vector issued", vec_req, 1);
        chk("R4 timer vector", vec_addr, exp_vec(0, 1));
        chk("R3 save strobe", save_stb, 1);
        chk("R3 gie cleared on take", gie, 0);
        cyc(1'b1);
        chk("R3 one-cycle vector", {vec_req, save_stb}, 0);

        // R6: multi-cycle instruction delays the vector
        tmr_uflow = 1; cyc(1'b1);
        cmd_ei = 1; cyc(1'b1);
        cyc(1'b1);
        cyc(1'b0);
        chk("R6 armed mid-instruction", vec_req, 0);
        cyc(1'b0);
        chk("R6 waits for instruction end", vec_req, 0);
        cyc(1'b1);
        chk("R6 vector at instruction end", vec_req, 1);

        // R4/R3: both pending, external first, timer flag survives
        wr_ctrl(4'b0011);
        ext_pin = 1; tmr_uflow = 1; idle(4);
        cmd_ei = 1; cyc(1'b1);
        cyc(1'b1); cyc(1'b1); cyc(1'b1);
        chk("R4 priority vector pulse", vec_req, 1);
        chk("R4 external wins", vec_addr, exp_vec(1, 1));
        cmd_ei = 1; cyc(1'b1);
        cyc(1'b1); cyc(1'b1); cyc(1'b1);
        chk("R3 timer flag kept after ext taken", vec_req, 1);
        chk("R3 then timer vector", vec_addr, exp_vec(0, 1));
        cmd_ei = 1; cyc(1'b1);
        idle(4);
        chk("R3 serviced flags cleared", vec_req, 0);

        // R5: enable immediately before return
        cmd_di = 1; cyc(1'b1);
        cmd_ei = 1; cyc(1'b1);
        chk("R5 gie off after ei", gie, 0);
        cmd_rti = 1; cyc(1'b1);
        chk("R5 gie on after return", gie, 1);
        chk("R5 restore strobe", restore_stb, 1);
        cyc(1'b1);
        chk("R5 restore one cycle", restore_stb, 0);
        cmd_di = 1; cyc(1'b1);

        // R2/R8: random underflows and skip tests against a sticky-flag model
        wr_ctrl(4'b0000);
        skip_tmr = 1; cyc(1'b1);
        model = 1'b0;
        for (int i = 0; i < 400; i++) begin
            logic t, s, e;
            t = ($urandom % 3) == 0;
            s = ($urandom % 2) == 0;
            e = ($urandom % 4) != 0;
            tmr_uflow = t;
            skip_tmr = s;
            cyc(e);
            if (s && e) begin
                chk("R2 random skip", skip_hit, model);
                model = t;
            end else begin
                model = model | t;
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule